// File: doc/BRIEF.md
# Condition Flag Unit with Evaluator

This block is a 64-bit integer arithmetic and logic unit with a four-bit status flag register: carry, zero, sign and overflow. Each cycle it computes a result from two operands and the selected operation. When flag writing is enabled and the operation is one that sets flags, the register captures the flags that the operation derives at the next clock edge.

A 4-bit condition select picks one of eleven named conditions. The block evaluates that condition from the registered flags. The one-bit outcome drives a branch-taken output and a set-byte output. The set-byte output merges the outcome into the low byte of a supplied destination value and keeps the upper bytes of that value.

Compare and test set the flags and do not write a result. The address-add operation does the opposite: it produces a sum and leaves the flags alone. Flag bits on `flags_o` are ordered {OF, SF, ZF, CF} from bit 3 down to bit 0.

Top module: `cfu_top`

## Requirements
- R1: Add (op 0) gives result a+b and result_we_o=1. It sets CF from the carry out of bit 63, ZF when the result is zero, SF from result bit 63, and OF when both operands have the same sign and the result's sign differs from it.
- R2: Subtract (op 1) gives result a-b and result_we_o=1. CF is the borrow, that is, the inverse of the carry out of a+~b+1. ZF and SF follow the result. OF is set when the operand signs differ and the result's sign differs from a's sign.
- R3: Compare (op 2) sets all four flags exactly as subtract would and drives result_we_o=0.
- R4: Test (op 3) drives result_we_o=0. It sets ZF when a&b is zero and SF from bit 63 of a&b, and it clears CF and OF.
- R5: AND (op 4), OR (op 5) and XOR (op 6) give the bitwise result with result_we_o=1. ZF and SF follow the result, and CF and OF are cleared.
- R6: Address-add (op 7) gives result a+b with result_we_o=1 and never changes the flags, even when flag_we_i is 1.
- R7: After reset the flags are 0. They change only on a clock edge where flag_we_i=1 and the operation is not address-add.
- R8: The condition codes on cond_i decode from the registered flags as follows: 1 equal ZF, 2 not-equal ~ZF, 3 negative SF, 4 nonnegative ~SF, 5 greater ~(SF^OF)&~ZF, 6 greater-or-equal ~(SF^OF), 7 less SF^OF, 8 less-or-equal (SF^OF)|ZF, 9 above ~CF&~ZF, 10 below CF.
- R9: Code 0 always evaluates true, whatever the flags. Codes 11 to 15 always evaluate false.
- R10: setb_o equals dest_i with bits 63:8 unchanged, bits 7:1 zero and bit 0 equal to the condition outcome.
- R11: branch_o equals the condition outcome for the selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| flag_we_i | input | 1 | Flag write enable |
| cond_i | input | 4 | Condition select |
| dest_i | input | 64 | Prior destination value for set-byte |
| result_o | output | 64 | Operation result |
| result_we_o | output | 1 | Result is to be written |
| flags_o | output | 4 | Registered flags {OF,SF,ZF,CF} |
| cond_o | output | 1 | Condition outcome |
| setb_o | output | 64 | Destination with set-byte merged |
| branch_o | output | 1 | Branch taken |

## Verification
The result and result-write outputs are combinational, so they are due in the same cycle as the operands. The bench samples them 1 ns after it drives the inputs, before the next rising edge. The flags appear one edge after a flag-setting operation. The condition, branch and set-byte outputs are derived from those flags and are due at that same edge. Each task therefore checks the flags and everything derived from them at the following falling edge, after flag_we_i has been dropped.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_CMP = 3'd2, OP_TST = 3'd3,
    OP_AND = 3'd4, OP_OR  = 3'd5, OP_XOR = 3'd6, OP_LEA = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    CC_ALW = 4'd0, CC_EQ = 4'd1, CC_NE = 4'd2, CC_NEG = 4'd3, CC_NNEG = 4'd4,
    CC_GT  = 4'd5, CC_GE = 4'd6, CC_LT = 4'd7, CC_LE  = 4'd8, CC_AB = 4'd9,
    CC_BL  = 4'd10
  } cc_e;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic cf;
  } flags_t;
endpackage

// File: rtl/cfu_alu.sv
module cfu_alu import cfu_pkg::*; #(
  parameter int W = 64
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output flags_t       flags_o,
  output logic         upd_o
);
  localparam int MSB = W - 1;

  logic [W:0]   add_s, sub_s;
  logic [W-1:0] and_v;
  op_e          op;

  assign op    = op_e'(op_i);
  assign add_s = {1'b0, a_i} + {1'b0, b_i};
  assign sub_s = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
  assign and_v = a_i & b_i;

  always_comb begin
    res_o    = '0;
    res_we_o = 1'b1;
    upd_o    = 1'b1;
    flags_o  = '0;
    unique case (op)
      OP_ADD, OP_LEA: begin
        res_o      = add_s[W-1:0];
        flags_o.cf = add_s[W];
        flags_o.of = (a_i[MSB] == b_i[MSB]) && (add_s[MSB] != a_i[MSB]);
        upd_o      = (op == OP_ADD);
      end
      OP_SUB, OP_CMP: begin
        res_o      = sub_s[W-1:0];
        flags_o.cf = ~sub_s[W];  // borrow
        flags_o.of = (a_i[MSB] != b_i[MSB]) && (sub_s[MSB] != a_i[MSB]);
        res_we_o   = (op == OP_SUB);
      end
      OP_TST: begin
        res_o    = and_v;
        res_we_o = 1'b0;
      end
      OP_AND:  res_o = and_v;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
    flags_o.zf = (res_o == '0);
    flags_o.sf = res_o[MSB];
  end
endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg import cfu_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  logic   upd_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_o <= '0;
    else if (we_i && upd_i) q_o <= d_i;
  end
endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval import cfu_pkg::*; #(
  parameter int CW = 4
) (
  input  flags_t        f_i,
  input  logic [CW-1:0] cc_i,
  output logic          hit_o
);
  logic lt;
  assign lt = f_i.sf ^ f_i.of;

  always_comb begin
    unique case (cc_i)
      CC_ALW:  hit_o = 1'b1;
      CC_EQ:   hit_o = f_i.zf;
      CC_NE:   hit_o = ~f_i.zf;
      CC_NEG:  hit_o = f_i.sf;
      CC_NNEG: hit_o = ~f_i.sf;
      CC_GT:   hit_o = ~lt & ~f_i.zf;
      CC_GE:   hit_o = ~lt;
      CC_LT:   hit_o = lt;
      CC_LE:   hit_o = lt | f_i.zf;
      CC_AB:   hit_o = ~f_i.cf & ~f_i.zf;
      CC_BL:   hit_o = f_i.cf;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfu_top.sv
module cfu_top import cfu_pkg::*; #(
  parameter int W  = 64,
  parameter int CW = 4,
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          flag_we_i,
  input  logic [CW-1:0] cond_i,
  input  logic [W-1:0]  dest_i,
  output logic [W-1:0]  result_o,
  output logic          result_we_o,
  output logic [3:0]    flags_o,
  output logic          cond_o,
  output logic [W-1:0]  setb_o,
  output logic          branch_o
);
  flags_t nxt_f, cur_f;
  logic   upd;

  cfu_alu #(.W(W)) u_alu (
    .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .res_o(result_o), .res_we_o(result_we_o), .flags_o(nxt_f), .upd_o(upd)
  );

  cfu_flag_reg u_freg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we_i), .upd_i(upd),
    .d_i(nxt_f), .q_o(cur_f)
  );

  cfu_cond_eval #(.CW(CW)) u_cond (
    .f_i(cur_f), .cc_i(cond_i), .hit_o(cond_o)
  );

  assign flags_o  = cur_f;
  assign branch_o = cond_o;
  assign setb_o   = {dest_i[W-1:BW], {(BW-1){1'b0}}, cond_o};
endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int W  = 64,
  parameter int CW = 4,
  parameter int BW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    op_i,
  input logic          flag_we_i,
  input logic [CW-1:0] cond_i,
  input logic [W-1:0]  dest_i,
  input logic          result_we_o,
  input logic [3:0]    flags_o,
  input logic          cond_o,
  input logic [W-1:0]  setb_o,
  input logic          branch_o
);
  p_lea_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd7 |=> $stable(flags_o));

  p_we_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  p_cmp_nowr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd2 |-> !result_we_o);

  p_tst_nowr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'd3 |-> !result_we_o);

  p_logic_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (op_i inside {3'd3, 3'd4, 3'd5, 3'd6})) |=> (!flags_o[0] && !flags_o[3]));

  p_always_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i == '0 |-> cond_o);

  p_unused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i > 4'd10 |-> !cond_o);

  p_setb_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setb_o[W-1:BW] == dest_i[W-1:BW]) && (setb_o[BW-1:0] == {{(BW-1){1'b0}}, cond_o}));

  p_branch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o == cond_o);
endmodule

bind cfu_top cfu_checker #(.W(W), .CW(CW), .BW(BW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .flag_we_i(flag_we_i),
  .cond_i(cond_i), .dest_i(dest_i), .result_we_o(result_we_o),
  .flags_o(flags_o), .cond_o(cond_o), .setb_o(setb_o), .branch_o(branch_o)
);

// File: tb/tb_cfu_top.sv
module tb_cfu_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0, dest_i = '0;
  logic        flag_we_i = 1'b0;
  logic [3:0]  cond_i = '0;
  logic [63:0] result_o, setb_o;
  logic        result_we_o, cond_o, branch_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  always #10 clk_i = ~clk_i;

  cfu_top dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive op; check combinational result now, flags after the edge
  task automatic run(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                     input logic we, input string tag, input logic [63:0] exp_res,
                     input logic exp_we, input logic [3:0] exp_f);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; flag_we_i = we;
    #1;
    chk({tag, " result"}, result_o, exp_res);
    chk({tag, " result_we"}, 64'(result_we_o), 64'(exp_we));
    @(negedge clk_i);
    flag_we_i = 1'b0;
    chk({tag, " flags"}, 64'(flags_o), 64'(exp_f));
  endtask

  task automatic cc(input logic [3:0] code, input logic exp, input string tag);
    cond_i = code;
    #1;
    chk({tag, " cond"}, 64'(cond_o), 64'(exp));
    chk({"R11 ", tag, " branch"}, 64'(branch_o), 64'(exp));
  endtask

  task automatic t_reset;
    chk("R7 reset flags", 64'(flags_o), 64'h0);
    cc(4'd1, 1'b0, "R8 eq after reset");
    cc(4'd6, 1'b1, "R8 ge after reset");
  endtask

  task automatic t_add;
    run(3'd0, 64'd5, 64'd7, 1'b1, "R1 add small", 64'd12, 1'b1, 4'b0000);
    run(3'd0, MAXP, 64'd1, 1'b1, "R1 add ovf", MINN, 1'b1, 4'b1100);
    run(3'd0, ONES, 64'd1, 1'b1, "R1 add carry", 64'd0, 1'b1, 4'b0011);
  endtask

  task automatic t_sub;
    run(3'd1, 64'd3, 64'd5, 1'b1, "R2 sub borrow", 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'b0101);
    run(3'd1, MINN, 64'd1, 1'b1, "R2 sub ovf", MAXP, 1'b1, 4'b1000);
  endtask

  task automatic t_cmp;
    run(3'd2, 64'd9, 64'd9, 1'b1, "R3 cmp eq", 64'd0, 1'b0, 4'b0010);
    cc(4'd1, 1'b1, "R8 eq");
    cc(4'd2, 1'b0, "R8 ne");
    cc(4'd5, 1'b0, "R8 gt");
    cc(4'd6, 1'b1, "R8 ge");
    cc(4'd8, 1'b1, "R8 le");
    cc(4'd9, 1'b0, "R8 above");
    cc(4'd10, 1'b0, "R8 below");
    run(3'd2, 64'd2, 64'd5, 1'b1, "R3 cmp lt", 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 4'b0101);
    cc(4'd7, 1'b1, "R8 lt");
    cc(4'd5, 1'b0, "R8 gt2");
    cc(4'd3, 1'b1, "R8 neg");
    cc(4'd4, 1'b0, "R8 nneg");
    cc(4'd10, 1'b1, "R8 below2");
    run(3'd2, ONES, 64'd1, 1'b1, "R3 cmp m1", 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 4'b0100);
    cc(4'd7, 1'b1, "R8 lt signed");
    cc(4'd9, 1'b1, "R8 above unsigned");
    cc(4'd10, 1'b0, "R8 below3");
    run(3'd2, MINN, 64'd1, 1'b1, "R3 cmp ovf", MAXP, 1'b0, 4'b1000);
    cc(4'd7, 1'b1, "R8 lt via of");
    cc(4'd5, 1'b0, "R8 gt via of");
  endtask

  task automatic t_test;
    run(3'd1, 64'd3, 64'd5, 1'b1, "R2 sub pre", 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'b0101);
    run(3'd3, 64'hF0, 64'h0F, 1'b1, "R4 test zero", 64'd0, 1'b0, 4'b0010);
    run(3'd2, 64'd2, 64'd5, 1'b1, "R3 cmp pre", 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 4'b0101);
    run(3'd3, MINN, ONES, 1'b1, "R4 test neg", MINN, 1'b0, 4'b0100);
  endtask

  task automatic t_logic;
    run(3'd1, MINN, 64'd1, 1'b1, "R2 sub pre2", MAXP, 1'b1, 4'b1000);
    run(3'd4, 64'hFF00, 64'h0FF0, 1'b1, "R5 and", 64'h0F00, 1'b1, 4'b0000);
    run(3'd1, 64'd3, 64'd5, 1'b1, "R2 sub pre3", 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'b0101);
    run(3'd5, MINN, 64'd1, 1'b1, "R5 or", 64'h8000_0000_0000_0001, 1'b1, 4'b0100);
    run(3'd6, 64'h1234, 64'h1234, 1'b1, "R5 xor", 64'd0, 1'b1, 4'b0010);
  endtask

  task automatic t_lea;
    run(3'd1, 64'd3, 64'd5, 1'b1, "R2 sub pre4", 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'b0101);
    run(3'd7, ONES, 64'd1, 1'b1, "R6 lea wrap", 64'd0, 1'b1, 4'b0101);
    run(3'd7, MAXP, 64'd1, 1'b1, "R6 lea ovf", MINN, 1'b1, 4'b0101);
    run(3'd0, ONES, 64'd1, 1'b0, "R7 add no we", 64'd0, 1'b1, 4'b0101);
    run(3'd2, 64'd4, 64'd4, 1'b0, "R7 cmp no we", 64'd0, 1'b0, 4'b0101);
  endtask

  task automatic t_special;
    run(3'd2, 64'd9, 64'd9, 1'b1, "R3 cmp eq2", 64'd0, 1'b0, 4'b0010);
    cc(4'd0, 1'b1, "R9 always zf");
    for (int c = 11; c < 16; c++) cc(4'(c), 1'b0, "R9 unused");
    run(3'd0, 64'd1, 64'd1, 1'b1, "R1 add clr", 64'd2, 1'b1, 4'b0000);
    cc(4'd0, 1'b1, "R9 always clear");
    for (int c = 11; c < 16; c++) cc(4'(c), 1'b0, "R9 unused2");
  endtask

  task automatic t_setb;
    dest_i = 64'h1234_5678_9ABC_DEFF;
    cc(4'd0, 1'b1, "R10 true");
    chk("R10 setb true", setb_o, 64'h1234_5678_9ABC_DE01);
    cc(4'd1, 1'b0, "R10 false");
    chk("R10 setb false", setb_o, 64'h1234_5678_9ABC_DE00);
    dest_i = 64'hA5A5_A5A5_A5A5_A5A5;
    cc(4'd2, 1'b1, "R10 ne");
    chk("R10 setb ne", setb_o, 64'hA5A5_A5A5_A5A5_A501);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_test();
    t_logic();
    t_lea();
    t_special();
    t_setb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule